// File: doc/BRIEF.md
# Configuration Access Lock Controller

This block decides whether commands aimed at a stored configuration image may proceed. A host issues one command per valid cycle on a small opcode field, with a 128-bit data field that carries a key where the command needs one. One clock later the block answers with a single-cycle grant or a single-cycle reject. The same clock edge updates its protection state.

The protection state has two independent parts. The first is a three-valued lock mode: open, locked under a stored key, or sealed for good. The second is a write-once flag that forbids erasing or reprogramming the image after it is set. A key-locked device returns to open only when the stored key is presented again and all 128 bits match. Every mismatched unlock attempt is counted in a saturating counter. Once the counter reaches a parameter limit, unlock attempts are refused until reset. The stored key never appears on any output.

Lock bits that would be non-volatile in silicon are modelled here as reset-cleared registers.

Top module: `cfg_lock_ctrl`

## Requirements
- R1: Exactly one of `rsp_grant`/`rsp_reject` is high for one cycle in the cycle after each cycle with `cmd_valid` high. Both stay low in the cycle after a cycle with `cmd_valid` low.
- R2: `lock_mode` encodes open as 0, key-locked as 1 and sealed as 2. After reset the block is open, the write-once flag is clear, the failed-attempt count is 0 and `unlock_blocked` is low.
- R3: READ (opcode 0) is granted only while open. ERASE (opcode 1) and PROGRAM (opcode 2) are granted only while open and the write-once flag is clear.
- R4: LOCK_KEY (opcode 3) is granted only while open. It stores `cmd_data` as the key and moves the mode to key-locked. While not open it is rejected, and the stored key is left unchanged.
- R5: UNLOCK (opcode 4) in key-locked mode, when not blocked and with `cmd_data` equal to the stored key, is granted. It returns the mode to open and clears the failed-attempt count.
- R6: UNLOCK in key-locked mode with a key that differs in any bit, including bit 0 or bit 127, is rejected. The mode does not change, and the failed-attempt count rises by one, saturating at LOCK_LIMIT.
- R7: While the count equals LOCK_LIMIT, `unlock_blocked` is high and every UNLOCK is rejected, even one carrying the correct key, without changing the mode. Only reset clears this condition.
- R8: SEAL (opcode 5) is granted only while open and sets the sealed mode. No command ever leaves the sealed mode, and every command is rejected while sealed.
- R9: BURN_OTP (opcode 6) is granted only while open and the flag is clear, and it sets the flag. The flag is never cleared by any command. With the flag set, READ is still granted while open.
- R10: UNLOCK outside key-locked mode, and the unused opcode 7, are rejected and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_data | input | 128 | Key field for LOCK_KEY and UNLOCK |
| rsp_grant | output | 1 | Previous command accepted |
| rsp_reject | output | 1 | Previous command refused |
| lock_mode | output | 2 | Current lock mode |
| otp_set | output | 1 | Write-once flag |
| unlock_blocked | output | 1 | Unlock attempts exhausted |
| fail_count | output | CNT_W | Failed unlock attempts since last success |

## Verification
The interesting coincidence is the failed-attempt accounting meeting the lockout gate. The mismatched UNLOCK that brings the count to LOCK_LIMIT is rejected in the same cycle that `unlock_blocked` rises. The bench issues wrong keys back to back, one of them differing only in the top bit, and checks the reject, the count and the blocked flag together in that response cycle. It then sends the correct key and requires a reject, an unchanged mode and an unchanged count.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

    typedef enum logic [1:0] {
        LM_OPEN   = 2'd0,
        LM_KEYED  = 2'd1,
        LM_SEALED = 2'd2
    } lock_mode_e;

    typedef enum logic [2:0] {
        OP_READ     = 3'd0,
        OP_ERASE    = 3'd1,
        OP_PROGRAM  = 3'd2,
        OP_LOCK_KEY = 3'd3,
        OP_UNLOCK   = 3'd4,
        OP_SEAL     = 3'd5,
        OP_BURN_OTP = 3'd6,
        OP_RSVD     = 3'd7
    } cmd_op_e;

endpackage

// File: rtl/cfg_key_cmp.sv
module cfg_key_cmp #(
    parameter int KEY_W  = 128,
    parameter int LANE_W = 32
) (
    input  logic [KEY_W-1:0] key_a,
    input  logic [KEY_W-1:0] key_b,
    output logic             match
);
    localparam int LANES = KEY_W / LANE_W;

    logic [LANES-1:0] lane_eq;

    // Per-lane equality, all lanes reduced in the same cycle
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (key_a[g*LANE_W +: LANE_W] == key_b[g*LANE_W +: LANE_W]);
    end

    assign match = &lane_eq;
endmodule

// File: rtl/cfg_fail_ctr.sv
module cfg_fail_ctr #(
    parameter int LOCK_LIMIT = 3,
    parameter int CNT_W      = 2
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_d,
    output logic             at_limit
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LOCK_LIMIT);

    assign at_limit = (cnt_q == LIM);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && !at_limit) begin
            cnt_d = cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_access_policy.sv
module cfg_access_policy
    import cfg_lock_pkg::*;
(
    input  logic       valid,
    input  cmd_op_e    op,
    input  lock_mode_e mode,
    input  logic       otp,
    input  logic       blocked,
    input  logic       key_match,
    output logic       grant,
    output logic       go_keyed,
    output logic       go_open,
    output logic       go_sealed,
    output logic       go_otp,
    output logic       fail_inc
);
    logic is_open;
    assign is_open = (mode == LM_OPEN);

    always_comb begin
        grant     = 1'b0;
        go_keyed  = 1'b0;
        go_open   = 1'b0;
        go_sealed = 1'b0;
        go_otp    = 1'b0;
        fail_inc  = 1'b0;
        if (valid) begin
            unique case (op)
                OP_READ:     grant = is_open;
                OP_ERASE,
                OP_PROGRAM:  grant = is_open && !otp;
                OP_LOCK_KEY: begin
                    grant    = is_open;
                    go_keyed = is_open;
                end
                OP_UNLOCK: begin
                    if (mode == LM_KEYED && !blocked) begin
                        grant    = key_match;
                        go_open  = key_match;
                        fail_inc = !key_match;
                    end
                end
                OP_SEAL: begin
                    grant     = is_open;
                    go_sealed = is_open;
                end
                OP_BURN_OTP: begin
                    grant  = is_open && !otp;
                    go_otp = is_open && !otp;
                end
                default:     grant = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl
    import cfg_lock_pkg::*;
#(
    parameter int KEY_W      = 128,
    parameter int LANE_W     = 32,
    parameter int LOCK_LIMIT = 3,
    parameter int CNT_W      = $clog2(LOCK_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [KEY_W-1:0] cmd_data,
    output logic             rsp_grant,
    output logic             rsp_reject,
    output logic [1:0]       lock_mode,
    output logic             otp_set,
    output logic             unlock_blocked,
    output logic [CNT_W-1:0] fail_count
);
    typedef struct packed {
        lock_mode_e       mode;
        logic             otp;
        logic [KEY_W-1:0] key;
        logic [CNT_W-1:0] fails;
        logic             grant;
        logic             reject;
    } st_t;

    st_t st_d, st_q;

    logic             key_match;
    logic             at_limit;
    logic [CNT_W-1:0] cnt_next;
    logic             pol_grant, go_keyed, go_open, go_sealed, go_otp, fail_inc;

    cfg_key_cmp #(
        .KEY_W  (KEY_W),
        .LANE_W (LANE_W)
    ) u_cmp (
        .key_a (cmd_data),
        .key_b (st_q.key),
        .match (key_match)
    );

    cfg_fail_ctr #(
        .LOCK_LIMIT (LOCK_LIMIT),
        .CNT_W      (CNT_W)
    ) u_ctr (
        .cnt_q    (st_q.fails),
        .inc      (fail_inc),
        .clr      (go_open),
        .cnt_d    (cnt_next),
        .at_limit (at_limit)
    );

    cfg_access_policy u_pol (
        .valid     (cmd_valid),
        .op        (cmd_op_e'(cmd_op)),
        .mode      (st_q.mode),
        .otp       (st_q.otp),
        .blocked   (at_limit),
        .key_match (key_match),
        .grant     (pol_grant),
        .go_keyed  (go_keyed),
        .go_open   (go_open),
        .go_sealed (go_sealed),
        .go_otp    (go_otp),
        .fail_inc  (fail_inc)
    );

    always_comb begin
        st_d        = st_q;
        st_d.grant  = cmd_valid && pol_grant;
        st_d.reject = cmd_valid && !pol_grant;
        st_d.fails  = cnt_next;
        if (go_keyed) begin
            st_d.mode = LM_KEYED;
            st_d.key  = cmd_data;
        end
        if (go_open)   st_d.mode = LM_OPEN;
        if (go_sealed) st_d.mode = LM_SEALED;
        if (go_otp)    st_d.otp  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: LM_OPEN, otp: 1'b0, key: '0, fails: '0,
                      grant: 1'b0, reject: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_grant      = st_q.grant;
    assign rsp_reject     = st_q.reject;
    assign lock_mode      = st_q.mode;
    assign otp_set        = st_q.otp;
    assign unlock_blocked = at_limit;
    assign fail_count     = st_q.fails;
endmodule

// File: rtl/cfg_lock_ctrl_chk.sv
module cfg_lock_ctrl_chk #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic             rsp_grant,
    input logic             rsp_reject,
    input logic [1:0]       lock_mode,
    input logic             otp_set,
    input logic             unlock_blocked,
    input logic [CNT_W-1:0] fail_count
);
    assert_one_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (rsp_grant ^ rsp_reject));

    assert_quiet_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (!rsp_grant && !rsp_reject));

    assert_locked_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd0 && lock_mode != 2'd0) |=> rsp_reject);

    assert_bad_key_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd4 && lock_mode == 2'd1 && !unlock_blocked)
            |=> (rsp_grant || fail_count == $past(fail_count) + 1'b1));

    assert_blocked_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_blocked |=> unlock_blocked);

    assert_blocked_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd4 && unlock_blocked) |=> (rsp_reject && $stable(lock_mode)));

    assert_sealed_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_mode == 2'd2) |=> (lock_mode == 2'd2));

    assert_otp_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        otp_set |=> otp_set);

    assert_otp_no_erase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2) && otp_set) |=> rsp_reject);
endmodule

bind cfg_lock_ctrl cfg_lock_ctrl_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_op         (cmd_op),
    .rsp_grant      (rsp_grant),
    .rsp_reject     (rsp_reject),
    .lock_mode      (lock_mode),
    .otp_set        (otp_set),
    .unlock_blocked (unlock_blocked),
    .fail_count     (fail_count)
);

// File: tb/cfg_lock_ctrl_tb.sv
module cfg_lock_ctrl_tb;
    localparam int KEY_W = 128;
    localparam int LIMIT = 3;
    localparam int CW    = 2;

    localparam logic [KEY_W-1:0] K1    = 128'h0123456789abcdef_fedcba9876543210;
    localparam logic [KEY_W-1:0] K2    = 128'h5a5a_a5a5_3c3c_c3c3_0f0f_f0f0_1111_eeee;
    localparam logic [KEY_W-1:0] K1_B0 = K1 ^ 128'd1;
    localparam logic [KEY_W-1:0] K1_HI = K1 ^ {1'b1, 127'd0};

    typedef struct packed {
        logic [23:0]      tag;
        logic [2:0]       op;
        logic [KEY_W-1:0] data;
        logic             grant;
        logic [1:0]       mode;
        logic             otp;
        logic [CW-1:0]    cnt;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{" R3", 3'd0, K1,    1'b1, 2'd0, 1'b0, 2'd0},  // R3 read while open
        '{" R3", 3'd2, K1,    1'b1, 2'd0, 1'b0, 2'd0},  // R3 program while open
        '{"R10", 3'd4, K1,    1'b0, 2'd0, 1'b0, 2'd0},  // R10 unlock when open
        '{"R10", 3'd7, K1,    1'b0, 2'd0, 1'b0, 2'd0},  // R10 unused opcode
        '{" R4", 3'd3, K1,    1'b1, 2'd1, 1'b0, 2'd0},  // R4 lock with K1
        '{" R3", 3'd0, K1,    1'b0, 2'd1, 1'b0, 2'd0},  // R3 read refused when locked
        '{" R3", 3'd1, K1,    1'b0, 2'd1, 1'b0, 2'd0},  // R3 erase refused when locked
        '{" R4", 3'd3, K2,    1'b0, 2'd1, 1'b0, 2'd0},  // R4 relock refused
        '{" R6", 3'd4, K1_B0, 1'b0, 2'd1, 1'b0, 2'd1},  // R6 bit 0 wrong
        '{" R6", 3'd4, K1_HI, 1'b0, 2'd1, 1'b0, 2'd2},  // R6 bit 127 wrong
        '{" R5", 3'd4, K1,    1'b1, 2'd0, 1'b0, 2'd0},  // R5 right key, R4 key kept
        '{" R9", 3'd6, K1,    1'b1, 2'd0, 1'b1, 2'd0},  // R9 burn flag
        '{" R9", 3'd1, K1,    1'b0, 2'd0, 1'b1, 2'd0},  // R9 erase refused
        '{" R9", 3'd2, K1,    1'b0, 2'd0, 1'b1, 2'd0},  // R9 program refused
        '{" R9", 3'd0, K1,    1'b1, 2'd0, 1'b1, 2'd0},  // R9 read still allowed
        '{" R9", 3'd6, K1,    1'b0, 2'd0, 1'b1, 2'd0}   // R9 second burn refused
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = '0;
    logic [KEY_W-1:0] cmd_data = '0;
    logic             rsp_grant, rsp_reject, otp_set, unlock_blocked;
    logic [1:0]       lock_mode;
    logic [CW-1:0]    fail_count;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;  // 50 MHz

    cfg_lock_ctrl #(.KEY_W(KEY_W), .LOCK_LIMIT(LIMIT)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_op         (cmd_op),
        .cmd_data       (cmd_data),
        .rsp_grant      (rsp_grant),
        .rsp_reject     (rsp_reject),
        .lock_mode      (lock_mode),
        .otp_set        (otp_set),
        .unlock_blocked (unlock_blocked),
        .fail_count     (fail_count)
    );

    // Snapshot: {grant, reject, mode, otp, blocked, count}
    function automatic logic [7:0] snap();
        return {rsp_grant, rsp_reject, lock_mode, otp_set, unlock_blocked, fail_count};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Drive at a falling edge; after it the response is sampled one edge later
    task automatic send(input logic [2:0] op, input logic [KEY_W-1:0] data);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = data;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        do_reset();
        // R2 reset state
        check("R2", "reset state", snap(), 8'b00_00_0_0_00);
        @(negedge clk);
        // R1 no command, no response
        check("R1", "idle quiet", snap(), 8'b00_00_0_0_00);

        for (int i = 0; i < NV; i++) begin
            send(VECS[i].op, VECS[i].data);
            check($sformatf("%s", VECS[i].tag), $sformatf("vector %0d", i), snap(),
                  {VECS[i].grant, !VECS[i].grant, VECS[i].mode, VECS[i].otp,
                   1'b0, VECS[i].cnt});
        end
        @(negedge clk);
        check("R1", "response lasts one cycle", snap(), 8'b00_00_1_0_00);

        // R7 lockout: lock with K2, exhaust attempts
        send(3'd3, K2);
        check("R4", "lock with K2", snap(), 8'b10_01_1_0_00);
        send(3'd4, K1);
        check("R6", "wrong key 1", snap(), 8'b01_01_1_0_01);
        send(3'd4, K1_HI);
        check("R6", "wrong key 2", snap(), 8'b01_01_1_0_10);
        send(3'd4, K2 ^ {1'b1, 127'd0});
        check("R7", "limit reached and blocked", snap(), 8'b01_01_1_1_11);
        send(3'd4, K2);
        check("R7", "right key refused when blocked", snap(), 8'b01_01_1_1_11);
        send(3'd4, K1);
        check("R6", "count saturates", snap(), 8'b01_01_1_1_11);
        send(3'd5, K1);
        check("R8", "seal refused while keyed", snap(), 8'b01_01_1_1_11);

        // R2 reset clears lockout
        do_reset();
        check("R2", "reset after lockout", snap(), 8'b00_00_0_0_00);

        // R8 seal
        send(3'd5, K1);
        check("R8", "seal granted", snap(), 8'b10_10_0_0_00);
        send(3'd4, K1);
        check("R8", "unlock refused sealed", snap(), 8'b01_10_0_0_00);
        send(3'd3, K1);
        check("R8", "lock refused sealed", snap(), 8'b01_10_0_0_00);
        send(3'd0, K1);
        check("R8", "read refused sealed", snap(), 8'b01_10_0_0_00);
        send(3'd6, K1);
        check("R8", "burn refused sealed", snap(), 8'b01_10_0_0_00);
        send(3'd5, K1);
        check("R8", "reseal refused", snap(), 8'b01_10_0_0_00);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule